// File: doc/BRIEF.md
# Encoded-Timeout System Watchdog

This block is a system watchdog that runs on one oscillator clock. Software arms it through a set of write strobes and must kick it regularly. The timeout is given as a small exponent code, not as a count. A code `c` means 2^(BASE_EXP + c) clock periods, and `BASE_EXP` defaults to 16. Two codes are held. The first-expiry code times only the first countdown after the watchdog is enabled. The normal code times every countdown after that.

At expiry the watchdog acts in one of two ways. In the reset response it raises a warm-reset request at once. In the interrupt-first response it raises an interrupt and reloads the counter. If that interrupt is still pending at the following expiry, it raises the reset request. Once the watchdog is enabled it cannot be stopped. The reset request stays high until the block itself is reset. The current count and the status flags are output directly, so that a bus adapter outside this block can read them.

Top module: `wdg_top`

## Requirements
- R1: After the block reset the watchdog is not running and the interrupt and reset request are low. The response is the reset response. Both codes hold `CODE_RST_FIRST` and `CODE_RST_NORM` (default 15), and `count` equals 2^(BASE_EXP+15)-1.
- R2: A timeout of code c lasts 2^(BASE_EXP+c) cycles. When the enable strobe (`en_we`=1, `en_wdata`=1) is taken at edge k, `count` becomes 2^(BASE_EXP+c_first)-1 at that edge, and the expiry takes effect at edge k+2^(BASE_EXP+c_first).
- R3: Every reload caused by an expiry, or by a kick while running, uses the normal code. After such a reload `count` is 2^(BASE_EXP+c_norm)-1.
- R4: Once running, the watchdog stays running. An enable write with `en_wdata`=0 has no effect, and counting goes on.
- R5: With `mode_wdata`=0 (reset response), an expiry sets `rst_req`. `rst_req` then stays high until `rst_n` is asserted.
- R6: With `mode_wdata`=1 (interrupt-first response), an expiry sets `irq` and reloads the counter. An expiry while `irq` is still set raises `rst_req`.
- R7: An `irq_clr_we` strobe clears `irq`. The next expiry then raises only `irq` again, not `rst_req`.
- R8: A kick (`kick_we`) reloads the counter and clears `irq`. A kick while running also ends the first-expiry phase, and a kick in the same cycle as a zero count prevents that expiry.
- R9: A code written while running leaves the current countdown unchanged and is used from the next reload on.
- R10: While the watchdog is not running, `count` holds its value. A kick reloads `count` from the first-expiry code. A code write only stores the code. Enabling starts the countdown from the reloaded value.
- R11: While running, and when neither a reload nor an expiry happens, `count` decreases by exactly one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low block reset, asynchronous |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value; 1 starts the watchdog, 0 is ignored once running |
| kick_we | input | 1 | Kick strobe: reload and clear the interrupt |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| mode_we | input | 1 | Response mode write strobe |
| mode_wdata | input | 1 | 0 = reset response, 1 = interrupt-first response |
| first_code_we | input | 1 | First-expiry code write strobe |
| first_code_wdata | input | CODE_W | First-expiry timeout code |
| norm_code_we | input | 1 | Normal code write strobe |
| norm_code_wdata | input | CODE_W | Normal timeout code |
| count | output | CNT_W | Current countdown value |
| running | output | 1 | Watchdog is enabled and counting |
| first_phase | output | 1 | First-expiry code is still the active one |
| irq | output | 1 | Pending timeout interrupt |
| rst_req | output | 1 | Sticky warm-reset request |

## Verification
Every strobe takes effect at the clock edge it is sampled on. A reload, a stored code or a cleared interrupt therefore shows on the outputs one edge after the strobe. An expiry shows exactly 2^(BASE_EXP+c) edges after the load that started that countdown. The bench drives strobes for exactly one edge and samples on the falling edge. It counts edges from each load: `count` is checked at zero on the edge before the expiry, and `irq` or `rst_req` on the edge after it. Each directed scenario starts from a fresh block reset, with `BASE_EXP` reduced to 2 so that the timeouts are short.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Response taken when the countdown expires
   typedef enum logic {
      WDG_RESP_RESET = 1'b0,
      WDG_RESP_IRQ   = 1'b1
   } wdg_resp_e;

   // Ones-mask decoder (shift) or per-code compare tree
   localparam int WDG_DEC_SHIFT = 0;
   localparam int WDG_DEC_MUX   = 1;

endpackage

// File: rtl/wdg_timeout_decode.sv
module wdg_timeout_decode
   import wdg_pkg::*;
#(
   parameter int BASE_EXP     = 16,
   parameter int CODE_W       = 4,
   parameter int DECODE_STYLE = WDG_DEC_SHIFT,
   localparam int MAX_CODE    = (1 << CODE_W) - 1,
   localparam int CNT_W       = BASE_EXP + MAX_CODE
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  load_val
);

   // load_val = 2^(BASE_EXP+code) - 1
   generate
      if (DECODE_STYLE == WDG_DEC_SHIFT) begin : g_shift
         localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
         logic [CODE_W-1:0] shamt;
         assign shamt    = CODE_W'(MAX_CODE) - code;
         assign load_val = ONES >> shamt;
      end else begin : g_mux
         always_comb begin
            load_val = '0;
            for (int i = 0; i <= MAX_CODE; i++) begin
               if (code == CODE_W'(i))
                  load_val = (CNT_W'(1) << (BASE_EXP + i)) - CNT_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
   import wdg_pkg::*;
#(
   parameter int CODE_W         = 4,
   parameter int CODE_RST_FIRST = 15,
   parameter int CODE_RST_NORM  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic              mode_wdata,
   input  logic              first_we,
   input  logic [CODE_W-1:0] first_wdata,
   input  logic              norm_we,
   input  logic [CODE_W-1:0] norm_wdata,
   input  logic              first_phase,
   input  logic              use_norm,
   output wdg_resp_e         mode_q,
   output logic [CODE_W-1:0] load_code
);

   logic [CODE_W-1:0] first_q;
   logic [CODE_W-1:0] norm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= WDG_RESP_RESET;
         first_q <= CODE_W'(CODE_RST_FIRST);
         norm_q  <= CODE_W'(CODE_RST_NORM);
      end else begin
         if (mode_we)  mode_q  <= wdg_resp_e'(mode_wdata);
         if (first_we) first_q <= first_wdata;
         if (norm_we)  norm_q  <= norm_wdata;
      end
   end

   // Stored codes only reach the counter through a reload
   always_comb begin
      if (use_norm || !first_phase) load_code = norm_q;
      else                          load_code = first_q;
   end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W              = 31,
   parameter logic [CNT_W-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= RST_VAL;
      else if (load)   count <= load_val;
      else if (dec)    count <= count - CNT_W'(1);
   end

   assign zero = (count == '0);

endmodule

// File: rtl/wdg_response.sv
module wdg_response
   import wdg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  logic      kick,
   input  logic      irq_clr,
   input  wdg_resp_e mode,
   output logic      irq,
   output logic      rst_req
);

   logic still_pending;
   logic irq_d;
   logic rst_d;

   // A clear in the expiry cycle counts as having happened first
   assign still_pending = irq && !irq_clr && !kick;

   always_comb begin
      irq_d = irq;
      rst_d = rst_req;
      if (kick || irq_clr) irq_d = 1'b0;
      if (expire) begin
         if (mode == WDG_RESP_RESET) begin
            rst_d = 1'b1;
         end else begin
            if (still_pending) rst_d = 1'b1;
            irq_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         irq     <= irq_d;
         rst_req <= rst_d;
      end
   end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
   import wdg_pkg::*;
#(
   parameter int BASE_EXP       = 16,
   parameter int CODE_W         = 4,
   parameter int CODE_RST_FIRST = 15,
   parameter int CODE_RST_NORM  = 15,
   parameter int DECODE_STYLE   = WDG_DEC_SHIFT,
   localparam int MAX_CODE      = (1 << CODE_W) - 1,
   localparam int CNT_W         = BASE_EXP + MAX_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_we,
   input  logic              en_wdata,
   input  logic              kick_we,
   input  logic              irq_clr_we,
   input  logic              mode_we,
   input  logic              mode_wdata,
   input  logic              first_code_we,
   input  logic [CODE_W-1:0] first_code_wdata,
   input  logic              norm_code_we,
   input  logic [CODE_W-1:0] norm_code_wdata,
   output logic [CNT_W-1:0]  count,
   output logic              running,
   output logic              first_phase,
   output logic              irq,
   output logic              rst_req
);

   localparam logic [CNT_W-1:0] RST_COUNT =
      {CNT_W{1'b1}} >> (MAX_CODE - CODE_RST_FIRST);

   // Elaboration-time parameter checks
   generate
      if (BASE_EXP < 1)
         $error("wdg_top: BASE_EXP must be at least 1");
      if (CODE_W < 1 || CODE_W > 5)
         $error("wdg_top: CODE_W must be 1..5");
      if (CODE_RST_FIRST < 0 || CODE_RST_FIRST > MAX_CODE)
         $error("wdg_top: CODE_RST_FIRST out of range");
      if (CODE_RST_NORM < 0 || CODE_RST_NORM > MAX_CODE)
         $error("wdg_top: CODE_RST_NORM out of range");
      if (DECODE_STYLE != WDG_DEC_SHIFT && DECODE_STYLE != WDG_DEC_MUX)
         $error("wdg_top: unknown DECODE_STYLE");
   endgenerate

   logic              start;
   logic              kick_run;
   logic              cnt_zero;
   logic              expire;
   logic              load;
   logic              use_norm;
   logic              dec;
   wdg_resp_e         mode_q;
   logic [CODE_W-1:0] load_code;
   logic [CNT_W-1:0]  load_val;

   assign start    = en_we && en_wdata && !running;
   assign kick_run = kick_we && running;
   assign expire   = running && cnt_zero && !kick_we;
   assign load     = start || kick_we || expire;
   assign use_norm = kick_run || expire;
   assign dec      = running && !load;

   // Enable is one-way; first phase ends at first expiry or running kick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         first_phase <= 1'b1;
      end else begin
         if (start)    running     <= 1'b1;
         if (use_norm) first_phase <= 1'b0;
      end
   end

   wdg_cfg_regs #(
      .CODE_W         (CODE_W),
      .CODE_RST_FIRST (CODE_RST_FIRST),
      .CODE_RST_NORM  (CODE_RST_NORM)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_we     (mode_we),
      .mode_wdata  (mode_wdata),
      .first_we    (first_code_we),
      .first_wdata (first_code_wdata),
      .norm_we     (norm_code_we),
      .norm_wdata  (norm_code_wdata),
      .first_phase (first_phase),
      .use_norm    (use_norm),
      .mode_q      (mode_q),
      .load_code   (load_code)
   );

   wdg_timeout_decode #(
      .BASE_EXP     (BASE_EXP),
      .CODE_W       (CODE_W),
      .DECODE_STYLE (DECODE_STYLE)
   ) u_dec (
      .code     (load_code),
      .load_val (load_val)
   );

   wdg_counter #(
      .CNT_W   (CNT_W),
      .RST_VAL (RST_COUNT)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .dec      (dec),
      .count    (count),
      .zero     (cnt_zero)
   );

   wdg_response u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .kick    (kick_we),
      .irq_clr (irq_clr_we),
      .mode    (mode_q),
      .irq     (irq),
      .rst_req (rst_req)
   );

endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk
   import wdg_pkg::*;
#(
   parameter int CNT_W = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_we,
   input logic             kick_we,
   input logic [CNT_W-1:0] count,
   input logic             running,
   input logic             irq,
   input logic             rst_req,
   input wdg_resp_e        mode_q
);

   // R4
   running_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R5
   rst_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   // R11
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !kick_we && count != '0) |=> (count == $past(count) - CNT_W'(1)));

   // R8
   kick_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_we |=> !irq);

   // R6
   irq_needs_irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(mode_q) == WDG_RESP_IRQ));

   // R5
   rst_from_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(running && count == '0 && !kick_we));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !kick_we && !en_we) |=> $stable(count));

endmodule

bind wdg_top wdg_top_chk #(.CNT_W(CNT_W)) u_wdg_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_we   (en_we),
   .kick_we (kick_we),
   .count   (count),
   .running (running),
   .irq     (irq),
   .rst_req (rst_req),
   .mode_q  (mode_q)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;

   localparam int BASE_EXP   = 2;
   localparam int CODE_W     = 4;
   localparam int CNT_W      = BASE_EXP + (1 << CODE_W) - 1;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en_we = 1'b0;
   logic              en_wdata = 1'b0;
   logic              kick_we = 1'b0;
   logic              irq_clr_we = 1'b0;
   logic              mode_we = 1'b0;
   logic              mode_wdata = 1'b0;
   logic              first_code_we = 1'b0;
   logic [CODE_W-1:0] first_code_wdata = '0;
   logic              norm_code_we = 1'b0;
   logic [CODE_W-1:0] norm_code_wdata = '0;
   logic [CNT_W-1:0]  count;
   logic              running;
   logic              first_phase;
   logic              irq;
   logic              rst_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdg_top #(.BASE_EXP(BASE_EXP), .CODE_W(CODE_W)) dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .en_we            (en_we),
      .en_wdata         (en_wdata),
      .kick_we          (kick_we),
      .irq_clr_we       (irq_clr_we),
      .mode_we          (mode_we),
      .mode_wdata       (mode_wdata),
      .first_code_we    (first_code_we),
      .first_code_wdata (first_code_wdata),
      .norm_code_we     (norm_code_we),
      .norm_code_wdata  (norm_code_wdata),
      .count            (count),
      .running          (running),
      .first_phase      (first_phase),
      .irq              (irq),
      .rst_req          (rst_req)
   );

   function automatic longint tmo(int code);
      return longint'(1) << (BASE_EXP + code);
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic wr_en(logic v);
      en_we = 1'b1; en_wdata = v;
      tick(1);
      en_we = 1'b0; en_wdata = 1'b0;
   endtask

   task automatic wr_kick();
      kick_we = 1'b1;
      tick(1);
      kick_we = 1'b0;
   endtask

   task automatic wr_clr();
      irq_clr_we = 1'b1;
      tick(1);
      irq_clr_we = 1'b0;
   endtask

   task automatic wr_mode(logic v);
      mode_we = 1'b1; mode_wdata = v;
      tick(1);
      mode_we = 1'b0;
   endtask

   task automatic wr_first(int c);
      first_code_we = 1'b1; first_code_wdata = CODE_W'(c);
      tick(1);
      first_code_we = 1'b0;
   endtask

   task automatic wr_norm(int c);
      norm_code_we = 1'b1; norm_code_wdata = CODE_W'(c);
      tick(1);
      norm_code_we = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1", "running", running, 0);
      check("R1", "irq", irq, 0);
      check("R1", "rst_req", rst_req, 0);
      check("R1", "count", count, tmo(15) - 1);
      check("R1", "first_phase", first_phase, 1);
   endtask

   task automatic t_reset_response();
      do_reset();
      wr_first(1);
      wr_norm(0);
      wr_en(1'b1);
      check("R2", "count after enable", count, tmo(1) - 1);
      check("R2", "running", running, 1);
      tick(3);
      check("R11", "count decrements", count, tmo(1) - 4);
      tick(4);
      check("R2", "count at zero", count, 0);
      check("R2", "no early reset", rst_req, 0);
      tick(1);
      check("R5", "reset request at expiry", rst_req, 1);
      check("R5", "no interrupt in reset mode", irq, 0);
      check("R3", "reload from normal code", count, tmo(0) - 1);
      tick(10);
      check("R5", "reset request sticky", rst_req, 1);
   endtask

   task automatic t_irq_escalate();
      do_reset();
      wr_mode(1'b1);
      wr_first(1);
      wr_norm(0);
      wr_en(1'b1);
      tick(7);
      check("R6", "irq before expiry", irq, 0);
      tick(1);
      check("R6", "irq at first expiry", irq, 1);
      check("R6", "no reset at first expiry", rst_req, 0);
      check("R3", "reload from normal code", count, tmo(0) - 1);
      tick(3);
      check("R6", "no reset before second expiry", rst_req, 0);
      tick(1);
      check("R6", "reset at second expiry", rst_req, 1);
   endtask

   task automatic t_irq_clear();
      do_reset();
      wr_mode(1'b1);
      wr_first(0);
      wr_norm(1);
      wr_en(1'b1);
      tick(4);
      check("R7", "irq raised", irq, 1);
      wr_clr();
      check("R7", "irq cleared", irq, 0);
      check("R7", "count unaffected by clear", count, tmo(1) - 2);
      tick(7);
      check("R7", "irq again at next expiry", irq, 1);
      check("R7", "no reset after clear", rst_req, 0);
   endtask

   task automatic t_kick();
      do_reset();
      wr_mode(1'b1);
      wr_first(2);
      wr_norm(1);
      wr_en(1'b1);
      check("R2", "first code load", count, tmo(2) - 1);
      tick(5);
      wr_kick();
      check("R8", "kick reloads normal", count, tmo(1) - 1);
      check("R8", "kick ends first phase", first_phase, 0);
      tick(7);
      check("R8", "count zero after kick reload", count, 0);
      check("R8", "no irq before expiry", irq, 0);
      tick(1);
      check("R8", "irq at expiry", irq, 1);
      wr_kick();
      check("R8", "kick clears irq", irq, 0);
      check("R8", "kick reload", count, tmo(1) - 1);
      tick(8);
      check("R8", "irq again", irq, 1);
      check("R8", "no reset after kick", rst_req, 0);
   endtask

   task automatic t_code_while_running();
      do_reset();
      wr_first(1);
      wr_norm(0);
      wr_en(1'b1);
      tick(2);
      wr_norm(2);
      check("R9", "normal write keeps countdown", count, tmo(1) - 4);
      wr_first(3);
      check("R9", "first write keeps countdown", count, tmo(1) - 5);
      tick(3);
      check("R9", "count zero", count, 0);
      tick(1);
      check("R9", "new normal code at reload", count, tmo(2) - 1);
   endtask

   task automatic t_no_disable();
      do_reset();
      wr_first(0);
      wr_en(1'b1);
      check("R4", "started", running, 1);
      wr_en(1'b0);
      check("R4", "still running", running, 1);
      check("R4", "still counting", count, tmo(0) - 2);
   endtask

   task automatic t_idle();
      do_reset();
      wr_en(1'b0);
      check("R10", "zero enable keeps idle", running, 0);
      wr_first(1);
      check("R10", "code write stores only", count, tmo(15) - 1);
      wr_kick();
      check("R10", "idle kick reloads", count, tmo(1) - 1);
      tick(4);
      check("R10", "idle count held", count, tmo(1) - 1);
      check("R10", "no reset while idle", rst_req, 0);
      wr_norm(0);
      check("R10", "normal write stores only", count, tmo(1) - 1);
      wr_en(1'b1);
      check("R10", "enable starts from reload", count, tmo(1) - 1);
      tick(7);
      check("R10", "count zero", count, 0);
      tick(1);
      check("R10", "reset after first timeout", rst_req, 1);
      check("R3", "normal reload", count, tmo(0) - 1);
   endtask

   initial begin : watchdog
      int n = 0;
      while (!done && n < WD_LIMIT) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=<%0d", n, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      t_reset_state();
      t_reset_response();
      t_irq_escalate();
      t_irq_clear();
      t_kick();
      t_code_while_running();
      t_no_disable();
      t_idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule